// File: doc/BRIEF.md
# Binary-Search Oscillator Tap Settling Supervisor

This block shortens the time a frequency-locked loop needs to lock its oscillator. Without it, the loop starts from tap zero and steps up one code at a time, which can take hundreds of reference periods. The supervisor instead runs a binary search over the 5-bit tap field. It writes a trial tap with the modulation field cleared and lets the loop run for a short fixed window. It then reads which way the loop wanted to move and keeps or drops the trial bit. With the default window of two reference cycles, a search of five trials takes 20 reference cycles.

When the search ends, the supervisor writes the final tap and pulses done for one cycle. It then hands the code back to the loop for normal tracking. While tracking, two optional behaviours are available. The first is a freeze. Once the observed code has risen and then starts to fall, the target has been crossed, so the loop is switched off and the code stays where it is. The second is a guard. If the modulation field stays at its all-ones value for a set number of cycles in a row, the supervisor raises a sticky request to move to the other, overlapping range setting. This keeps the loop away from the tap/modulation boundary where the tap may step wrongly.

The controller is a single state machine with eight states:

| State | Role | Leaves on |
|---|---|---|
| IDLE | Waits for a start. | IDLE→LOAD on start. |
| LOAD | Writes the trial code with the loop off. | LOAD→RUN always. |
| RUN | Loop enabled for the trial window. | RUN→JUDGE when the window expires. |
| JUDGE | Loop off; direction sampled. | JUDGE→LOAD if trials remain; JUDGE→FINAL after the last one. |
| FINAL | Writes the result. | FINAL→DONE always. |
| DONE | Pulses done. | DONE→TRACK always. |
| TRACK | Loop enabled, code monitored. | TRACK→LOAD on start; TRACK→HOLD on a freeze. |
| HOLD | Loop frozen. | HOLD→LOAD on start. |

Top module: `dco_sar_settle`

## Requirements
- R1: After reset the outputs are as follows: `loop_en_o`, `code_wr_o`, `done_o` and `swap_req_o` are 0, and `code_o` is 0.
- R2: Code words are laid out as tap in bits [9:5] and modulation in bits [4:0]. One cycle after a start is accepted, the first trial write carries tap 16 with modulation 0. Every write has modulation 0.
- R3: Trial k (k = 0..4) tests bit 4-k on top of the bits already kept. The bit is kept when `dir_up_i` is 1 in the JUDGE cycle; 1 means the loop wanted a higher code. The next trial is therefore the current tap plus or minus half the previous step. The final tap is the largest tap whose trials all saw up.
- R4: Each trial lasts four cycles. It starts with one write cycle with the loop off. The loop is then enabled for exactly TRIAL_CYC cycles (default 2). The trial ends with one JUDGE cycle with the loop off.
- R5: After the fifth JUDGE, the final code is written in one cycle, and `done_o` is high for exactly one cycle in the next. With default parameters `done_o` rises 22 cycles after the start is sampled.
- R6: From the cycle after done, the loop is enabled (TRACK).
- R7: In TRACK with `freeze_en_i` = 1, the loop is switched off once the observed code has risen at least once since entering TRACK and then falls below its value in the previous cycle. It stays off until the next start. With `freeze_en_i` = 0 a fall has no effect.
- R8: In TRACK with `guard_en_i` = 1, `swap_req_o` goes high when the modulation field of `obs_code_i` has been 31 for GUARD_CYC consecutive cycles (default 4). It then stays high.
- R9: A start during LOAD, RUN, JUDGE, FINAL or DONE is ignored, and the search continues unchanged.
- R10: A start in IDLE, TRACK or HOLD is accepted, restarts the search and clears `swap_req_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Search request |
| done_o | output | 1 | One-cycle search-complete pulse |
| code_wr_o | output | 1 | Code write strobe |
| code_o | output | 10 | Code to write: tap [9:5], modulation [4:0] |
| loop_en_o | output | 1 | Frequency loop enable |
| dir_up_i | input | 1 | Loop adjustment direction, 1 = up |
| obs_code_i | input | 10 | Code currently held by the loop |
| freeze_en_i | input | 1 | Freeze the loop after the target is crossed |
| guard_en_i | input | 1 | Enable the modulation-31 guard |
| swap_req_o | output | 1 | Request to change to the alternative range |

## Verification
Some rules can be stated as local cycle relations, and the assertions check these on every cycle. These are:
- a write always has modulation cleared and the loop off;
- the first write after an accepted start is the midpoint tap;
- done lasts one cycle and is followed by an enabled loop;
- a held freeze keeps the loop off;
- a start during a trial does not disturb it;
- the guard request is sticky until cleared.

Other behaviour is end to end and only the bench's scenarios can show it. This covers whether the five trials converge on the right tap for low, high, mid and edge targets. It also covers the exact 22-cycle latency, and whether a rise-then-fall pattern or a run of modulation-31 codes triggers at the right cycle and not before.

// File: rtl/dco_sar_pkg.sv
package dco_sar_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_RUN,
        ST_JUDGE,
        ST_FINAL,
        ST_DONE,
        ST_TRACK,
        ST_HOLD
    } sar_state_t;

endpackage

// File: rtl/dco_sar_bits.sv
// Successive-approximation register over the tap field.
module dco_sar_bits #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         init_i,
    input  logic         step_i,
    input  logic         dir_up_i,
    output logic [W-1:0] trial_o,
    output logic [W-1:0] acc_o,
    output logic         last_o
);
    localparam int IW = (W > 1) ? $clog2(W) : 1;

    logic [IW-1:0] idx;
    logic [W-1:0]  probe;

    assign probe   = W'(1) << idx;
    assign trial_o = acc_o | probe;
    assign last_o  = (idx == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_o <= '0;
            idx   <= IW'(W - 1);
        end else if (init_i) begin
            acc_o <= '0;
            idx   <= IW'(W - 1);
        end else if (step_i) begin
            if (dir_up_i) begin
                acc_o <= acc_o | probe;
            end
            if (idx != '0) begin
                idx <= idx - 1'b1;
            end
        end
    end

    AST_STEP_DESCENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !init_i && !last_o) |=> (idx == $past(idx) - 1'b1)); // R3

    AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !init_i) |=> ((acc_o & ~$past(probe)) == ($past(acc_o) & ~$past(probe)))); // R3

endmodule

// File: rtl/dco_sar_timer.sv
// Counts the trial window while the loop is enabled.
module dco_sar_timer #(
    parameter int TRIAL_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expire_o
);
    localparam int CW = (TRIAL_CYC > 1) ? $clog2(TRIAL_CYC) : 1;

    logic [CW-1:0] cnt;

    assign expire_o = run_i && (cnt == CW'(TRIAL_CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run_i) begin
            cnt <= '0;
        end else if (!expire_o) begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_TIMER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (cnt == '0)); // R4

endmodule

// File: rtl/dco_sar_monitor.sv
// Watches the tracking loop: crossing detection and modulation-31 guard.
module dco_sar_monitor #(
    parameter int CODE_W    = 10,
    parameter int MOD_W     = 5,
    parameter int GUARD_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active_i,
    input  logic              clear_i,
    input  logic              guard_en_i,
    input  logic [CODE_W-1:0] obs_i,
    output logic              fall_o,
    output logic              swap_o
);
    localparam int GW = (GUARD_CYC > 1) ? $clog2(GUARD_CYC) : 1;

    logic [CODE_W-1:0] prev;
    logic              valid;
    logic              rise;
    logic [GW-1:0]     gcnt;
    logic              mod_full;

    assign mod_full = &obs_i[MOD_W-1:0];
    assign fall_o   = active_i && valid && rise && (obs_i < prev);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev  <= '0;
            valid <= 1'b0;
            rise  <= 1'b0;
        end else begin
            prev <= obs_i;
            if (active_i) begin
                valid <= 1'b1;
                if (valid && (obs_i > prev)) begin
                    rise <= 1'b1;
                end
            end else begin
                valid <= 1'b0;
                rise  <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gcnt   <= '0;
            swap_o <= 1'b0;
        end else begin
            if (active_i && guard_en_i && mod_full) begin
                if (gcnt == GW'(GUARD_CYC - 1)) begin
                    swap_o <= 1'b1;
                end else begin
                    gcnt <= gcnt + 1'b1;
                end
            end else begin
                gcnt <= '0;
            end
            if (clear_i) begin
                swap_o <= 1'b0;
            end
        end
    end

    AST_SWAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_o && !clear_i) |=> swap_o); // R8

    AST_SWAP_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> !swap_o); // R10

    AST_SWAP_NEEDS_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(swap_o) |-> $past(guard_en_i && mod_full && active_i)); // R8

endmodule

// File: rtl/dco_sar_settle.sv
// Binary-search tap settling supervisor for a frequency-locked loop.
module dco_sar_settle
    import dco_sar_pkg::*;
#(
    parameter int TAP_W     = 5,
    parameter int MOD_W     = 5,
    parameter int TRIAL_CYC = 2,
    parameter int GUARD_CYC = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    output logic                   done_o,
    output logic                   code_wr_o,
    output logic [TAP_W+MOD_W-1:0] code_o,
    output logic                   loop_en_o,
    input  logic                   dir_up_i,
    input  logic [TAP_W+MOD_W-1:0] obs_code_i,
    input  logic                   freeze_en_i,
    input  logic                   guard_en_i,
    output logic                   swap_req_o
);
    localparam int CODE_W = TAP_W + MOD_W;
    localparam logic [TAP_W-1:0] TAP_MID = TAP_W'(1) << (TAP_W - 1);

    sar_state_t       state, state_nx;
    logic             start_acc;
    logic             expire;
    logic             last_trial;
    logic             fall;
    logic [TAP_W-1:0] trial_tap;
    logic [TAP_W-1:0] kept_tap;

    assign start_acc = start_i &&
        ((state == ST_IDLE) || (state == ST_TRACK) || (state == ST_HOLD));

    dco_sar_bits #(.W(TAP_W)) u_bits (
        .clk      (clk),
        .rst_n    (rst_n),
        .init_i   (start_acc),
        .step_i   (state == ST_JUDGE),
        .dir_up_i (dir_up_i),
        .trial_o  (trial_tap),
        .acc_o    (kept_tap),
        .last_o   (last_trial)
    );

    dco_sar_timer #(.TRIAL_CYC(TRIAL_CYC)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (state == ST_RUN),
        .expire_o (expire)
    );

    dco_sar_monitor #(.CODE_W(CODE_W), .MOD_W(MOD_W), .GUARD_CYC(GUARD_CYC)) u_mon (
        .clk        (clk),
        .rst_n      (rst_n),
        .active_i   (state == ST_TRACK),
        .clear_i    (start_acc),
        .guard_en_i (guard_en_i),
        .obs_i      (obs_code_i),
        .fall_o     (fall),
        .swap_o     (swap_req_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start_i) state_nx = ST_LOAD;
            ST_LOAD:  state_nx = ST_RUN;
            ST_RUN:   if (expire) state_nx = ST_JUDGE;
            ST_JUDGE: state_nx = last_trial ? ST_FINAL : ST_LOAD;
            ST_FINAL: state_nx = ST_DONE;
            ST_DONE:  state_nx = ST_TRACK;
            ST_TRACK: begin
                if (start_i) begin
                    state_nx = ST_LOAD;
                end else if (freeze_en_i && fall) begin
                    state_nx = ST_HOLD;
                end
            end
            ST_HOLD:  if (start_i) state_nx = ST_LOAD;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        code_wr_o = 1'b0;
        code_o    = '0;
        loop_en_o = 1'b0;
        done_o    = 1'b0;
        unique case (state)
            ST_LOAD: begin
                code_wr_o = 1'b1;
                code_o    = {trial_tap, {MOD_W{1'b0}}};
            end
            ST_RUN:   loop_en_o = 1'b1;
            ST_FINAL: begin
                code_wr_o = 1'b1;
                code_o    = {kept_tap, {MOD_W{1'b0}}};
            end
            ST_DONE:  done_o = 1'b1;
            ST_TRACK: loop_en_o = 1'b1;
            default: ;
        endcase
    end

    AST_FIRST_PROBE: assert property (@(posedge clk) disable iff (!rst_n)
        start_acc |=> (code_wr_o && (code_o[CODE_W-1:MOD_W] == TAP_MID))); // R2

    AST_MOD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        code_wr_o |-> (code_o[MOD_W-1:0] == '0)); // R2

    AST_WR_LOOP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        code_wr_o |-> !loop_en_o); // R4

    AST_LOAD_THEN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD) |=> loop_en_o); // R4

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R5

    AST_DONE_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> loop_en_o); // R6

    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_HOLD) && !start_i) |=> !loop_en_o); // R7

    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_RUN) && start_i) |=> ((state == ST_RUN) || (state == ST_JUDGE))); // R9

endmodule

// File: tb/dco_sar_settle_test.sv
module dco_sar_settle_test;

    localparam int M_IDLE = 0, M_SRCH = 1, M_FIN = 2, M_DONE = 3, M_TRK = 4, M_HOLD = 5;
    localparam int GUARD = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       done_o, code_wr_o, loop_en_o, swap_req_o;
    logic [9:0] code_o;
    logic       dir_up_i;
    logic [9:0] obs_code_i = '0;
    logic       freeze_en_i = 1'b0;
    logic       guard_en_i = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int target = 0;
    int loop_tap = 0;

    always #4 clk = ~clk;

    assign dir_up_i = (loop_tap <= target);

    dco_sar_settle uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .done_o     (done_o),
        .code_wr_o  (code_wr_o),
        .code_o     (code_o),
        .loop_en_o  (loop_en_o),
        .dir_up_i   (dir_up_i),
        .obs_code_i (obs_code_i),
        .freeze_en_i(freeze_en_i),
        .guard_en_i (guard_en_i),
        .swap_req_o (swap_req_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // loop stand-in: remembers the last tap written
    always @(negedge clk) if (code_wr_o) loop_tap = int'(code_o[9:5]);

    // behavioural reference model
    int m_mode, m_cnt, m_acc, m_prev, m_g;
    bit m_valid, m_rise, m_swap;
    always @(posedge clk or negedge rst_n) begin
        int cur;
        bit fall, acc_ok;
        if (!rst_n) begin
            m_mode = M_IDLE; m_cnt = 0; m_acc = 0; m_prev = 0; m_g = 0;
            m_valid = 0; m_rise = 0; m_swap = 0;
        end else begin
            cur = int'(obs_code_i);
            fall = (m_mode == M_TRK) && m_valid && m_rise && (cur < m_prev);
            acc_ok = start_i && (m_mode == M_IDLE || m_mode == M_TRK || m_mode == M_HOLD);
            if (m_mode == M_TRK) begin
                if (m_valid && cur > m_prev) m_rise = 1;
                m_valid = 1;
                if (guard_en_i && (cur % 32) == 31) begin
                    if (m_g == GUARD - 1) m_swap = 1; else m_g++;
                end else m_g = 0;
            end else begin
                m_valid = 0; m_rise = 0; m_g = 0;
            end
            m_prev = cur;
            if (acc_ok) m_swap = 0;
            case (m_mode)
                M_SRCH: begin
                    if (m_cnt % 4 == 3 && dir_up_i) m_acc = m_acc | (1 << (4 - m_cnt / 4));
                    m_cnt++;
                    if (m_cnt == 20) m_mode = M_FIN;
                end
                M_FIN:  m_mode = M_DONE;
                M_DONE: m_mode = M_TRK;
                M_TRK:  if (!acc_ok && freeze_en_i && fall) m_mode = M_HOLD;
                default: ;
            endcase
            if (acc_ok) begin m_mode = M_SRCH; m_cnt = 0; m_acc = 0; end
        end
    end

    // per-cycle comparison
    always @(negedge clk) if (rst_n) begin
        int e_wr, e_code, e_en;
        e_wr = 0; e_code = 0; e_en = 0;
        if (m_mode == M_SRCH) begin
            if (m_cnt % 4 == 0) begin
                e_wr = 1; e_code = (m_acc | (1 << (4 - m_cnt / 4))) << 5;
            end
            if (m_cnt % 4 == 1 || m_cnt % 4 == 2) e_en = 1;
        end
        if (m_mode == M_FIN) begin e_wr = 1; e_code = m_acc << 5; end
        if (m_mode == M_TRK) e_en = 1;
        chk("R4 code_wr_o", int'(code_wr_o), e_wr);
        chk("R3 code_o", int'(code_o), e_code);
        chk("R4 R6 loop_en_o", int'(loop_en_o), e_en);
        chk("R5 done_o", int'(done_o), int'(m_mode == M_DONE));
        chk("R8 swap_req_o", int'(swap_req_o), int'(m_swap));
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    task automatic search(input int tgt, input bit inject);
        int n;
        target = tgt;
        @(negedge clk);
        start_i = 1'b1;
        n = 0;
        while (n < 40) begin
            @(negedge clk);
            n++;
            if (n == 1) begin
                start_i = 1'b0;
                chk("R2 first trial code", int'(code_o), 16 << 5);
            end
            if (inject && n == 9)  start_i = 1'b1;   // R9 start mid-search
            if (inject && n == 10) start_i = 1'b0;
            if (done_o) break;
        end
        chk("R5 start-to-done cycles", n, 22);
        chk("R3 final tap", loop_tap, tgt);
    endtask

    task automatic obs_seq(input int v);
        @(negedge clk);
        obs_code_i = 10'(v);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 loop_en_o", int'(loop_en_o), 0);
        chk("R1 code_wr_o", int'(code_wr_o), 0);
        chk("R1 done_o", int'(done_o), 0);
        chk("R1 swap_req_o", int'(swap_req_o), 0);
        chk("R1 code_o", int'(code_o), 0);
        rst_n = 1'b1;

        search(20, 0);
        @(negedge clk);
        chk("R6 loop enabled after done", int'(loop_en_o), 1);

        // freeze disabled: rise then fall keeps tracking
        obs_seq(100); obs_seq(120); obs_seq(110); obs_seq(90);
        repeat (2) @(negedge clk);
        chk("R7 no freeze when disabled", int'(loop_en_o), 1);

        // freeze enabled
        freeze_en_i = 1'b1;
        obs_seq(200); obs_seq(210); obs_seq(205);
        repeat (2) @(negedge clk);
        chk("R7 frozen after crossing", int'(loop_en_o), 0);
        obs_seq(300); obs_seq(100);
        chk("R7 stays frozen", int'(loop_en_o), 0);

        freeze_en_i = 1'b0;
        search(0, 0);        // R10 restart from hold
        search(31, 1);       // R9 start during search ignored

        // guard: too short a run
        guard_en_i = 1'b1;
        obs_seq((10 << 5) | 31); obs_seq((10 << 5) | 31); obs_seq((10 << 5) | 31);
        obs_seq(10 << 5);
        @(negedge clk);
        chk("R8 short run no request", int'(swap_req_o), 0);
        repeat (6) obs_seq((10 << 5) | 31);
        @(negedge clk);
        chk("R8 request after run", int'(swap_req_o), 1);
        repeat (3) obs_seq((10 << 5) | 3);
        chk("R8 request sticky", int'(swap_req_o), 1);

        search(13, 0);
        chk("R10 request cleared by start", int'(swap_req_o), 0);
        guard_en_i = 1'b0;
        search(7, 0);
        search(16, 0);

        repeat (4) @(negedge clk);
        summary();
        $finish;
    end

endmodule